// File: doc/BRIEF.md
# Two-Word Register CPU

A small multicycle 32-bit processor core. Its instruction set is built around the operators of the C language: an unconditional jump, six conditional jumps, an immediate move, a word load, a word store, two shifts, NOT, AND, OR, XOR and ADD. Each instruction word carries an opcode and three register index fields. Jumps and the immediate move take a second word, which holds the absolute target or the 32-bit constant. Because of that second word, the program counter steps by one or by two depending on the opcode.

The core holds the program counter, the instruction decoder, a 32-entry register file, the branch comparator and the ALU. Instructions are read through a word-addressed instruction port with a one-cycle read latency. Loads and stores go through a separate word-addressed data port with the same latency and a single-cycle write enable. Every instruction first passes through a fetch state and a decode state. A two-word instruction then spends one cycle on its operand word, and every instruction ends with an execute cycle. A load adds one write-back cycle.

Top module: `wordpair_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter and all 32 registers to zero. In the first cycle after reset the instruction address is 0 and the data write enable is low.
- R2: An instruction word has the opcode in bits 31:24 and the register fields a, b and c in bits 23:16, 15:8 and 7:0. Only the low 5 bits of each field select a register.
- R3: MOV (opcode 8) writes the following word into register a and advances the program counter by 2.
- R4: SHL (12), SHR (13), AND (15), OR (16), XOR (17) and ADD (18) write r[b] op r[c] into r[a] and advance the program counter by 1. ADD wraps modulo 2^32. Both shifts are logical, the shift amount is the whole value of r[c], and an amount of 32 or more yields 0.
- R5: NOT (14) writes ~r[b] into r[a] and advances the program counter by 1.
- R6: JMP (1) loads the program counter from the following word.
- R7: JE (2), JNE (3), JG (4), JGE (5), JL (6) and JLE (7) compare r[a] with r[b] as unsigned numbers. When the condition holds, the program counter loads the following word. Otherwise it advances by 2.
- R8: STO (11) writes r[b] to the data address r[a] with a one-cycle write pulse and advances the program counter by 1.
- R9: LDA (10) loads r[a] from the data word at address r[b] and advances the program counter by 1.
- R10: NOP (0) and the undefined opcodes 9 and 19 to 255 are one word long. They change no register and write no memory.
- R11: A one-word instruction takes 3 cycles, and a two-word instruction or LDA takes 4 cycles.
- R12: The xorshift32 loop program (seed 1; shifts of 13 left, 17 right, 5 left) stores each successive value at successive data addresses starting at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IADDR_W | Instruction word address |
| imem_rdata | input | XLEN | Instruction word, one cycle after the address |
| dmem_addr | output | DADDR_W | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | XLEN | Load data, one cycle after the address |

## Verification
In the execute cycle a single register can be both read and written. An ALU operation whose destination is also a source must use the old value and then replace it, and a store whose address and data registers are the same must still drive both ports from that one register. Random programs draw their register fields from a pool of only eight registers, with random upper field bits, so these collisions come up often. A directed `STO D,D` and the xorshift loop's `XOR A,A,G` hit them deliberately. The bench judges the result by comparing the stored memory image against a bench-side interpreter of the instruction set and against direct xorshift arithmetic.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;

    typedef logic [7:0] opcode_t;

    // opcode values are fixed by the instruction encoding
    localparam opcode_t OP_NOP   = 8'd0;
    localparam opcode_t OP_JMP   = 8'd1;
    localparam opcode_t OP_JEQ   = 8'd2;
    localparam opcode_t OP_JNE   = 8'd3;
    localparam opcode_t OP_JGT   = 8'd4;
    localparam opcode_t OP_JGE   = 8'd5;
    localparam opcode_t OP_JLT   = 8'd6;
    localparam opcode_t OP_JLE   = 8'd7;
    localparam opcode_t OP_MOVI  = 8'd8;
    localparam opcode_t OP_LOAD  = 8'd10;
    localparam opcode_t OP_STORE = 8'd11;
    localparam opcode_t OP_SHL   = 8'd12;
    localparam opcode_t OP_SHR   = 8'd13;
    localparam opcode_t OP_NOT   = 8'd14;
    localparam opcode_t OP_AND   = 8'd15;
    localparam opcode_t OP_OR    = 8'd16;
    localparam opcode_t OP_XOR   = 8'd17;
    localparam opcode_t OP_ADD   = 8'd18;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPND,
        ST_EXEC,
        ST_LOAD
    } state_e;

    typedef struct packed {
        opcode_t    op;
        logic [7:0] fa;
        logic [7:0] fb;
        logic [7:0] fc;
    } insn_s;

    function automatic logic is_two_word(opcode_t op);
        return (op >= OP_JMP) && (op <= OP_MOVI);
    endfunction

    function automatic logic is_cond_branch(opcode_t op);
        return (op >= OP_JEQ) && (op <= OP_JLE);
    endfunction

    function automatic logic is_alu_op(opcode_t op);
        return (op >= OP_SHL) && (op <= OP_ADD);
    endfunction

endpackage

// File: rtl/wpc_regfile.sv
`timescale 1ns/1ps
module wpc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra_a,
    input  logic [$clog2(NREG)-1:0] ra_b,
    input  logic [$clog2(NREG)-1:0] ra_c,
    output logic [XLEN-1:0]         rd_a,
    output logic [XLEN-1:0]         rd_b,
    output logic [XLEN-1:0]         rd_c,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [XLEN-1:0]         wdata
);
    localparam int IW = $clog2(NREG);

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (we && (waddr == IW'(i))) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            regs_q[i] <= rst ? '0 : regs_d[i];
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];
    assign rd_c = regs_q[ra_c];

    // R2
    reg_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/wpc_alu.sv
`timescale 1ns/1ps
module wpc_alu
    import wpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  opcode_t         op,
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    output logic [XLEN-1:0] res
);
    localparam int SHW = $clog2(XLEN);

    logic            shift_big;
    logic [SHW-1:0]  shamt;

    assign shift_big = |y[XLEN-1:SHW];
    assign shamt     = y[SHW-1:0];

    always_comb begin
        case (op)
            OP_SHL:  res = shift_big ? '0 : (x << shamt);
            OP_SHR:  res = shift_big ? '0 : (x >> shamt);
            OP_NOT:  res = ~x;
            OP_AND:  res = x & y;
            OP_OR:   res = x | y;
            OP_XOR:  res = x ^ y;
            OP_ADD:  res = x + y;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/wpc_branch_cmp.sv
`timescale 1ns/1ps
module wpc_branch_cmp
    import wpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  opcode_t         op,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            take
);
    logic eq, lt;

    assign eq = (lhs == rhs);
    assign lt = (lhs < rhs);

    always_comb begin
        case (op)
            OP_JMP:  take = 1'b1;
            OP_JEQ:  take = eq;
            OP_JNE:  take = !eq;
            OP_JGT:  take = !lt && !eq;
            OP_JGE:  take = !lt;
            OP_JLT:  take = lt;
            OP_JLE:  take = lt || eq;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/wordpair_cpu.sv
`timescale 1ns/1ps
module wordpair_cpu
    import wpc_pkg::*;
#(
    parameter int IADDR_W = 16,
    parameter int DADDR_W = 16,
    parameter int XLEN    = 32,
    parameter int NREG    = 32
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [XLEN-1:0]    imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    input  logic [XLEN-1:0]    dmem_rdata
);
    localparam int RIDX_W = $clog2(NREG);

    typedef struct packed {
        state_e          st;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] imm;
    } core_s;

    core_s cur_q, nxt_d;
    insn_s ins;

    logic [XLEN-1:0]   rd_a, rd_b, rd_c;
    logic [XLEN-1:0]   alu_res;
    logic              take;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic [XLEN-1:0]   pc_inc1, pc_inc2;

    assign ins     = insn_s'(cur_q.ir[31:0]);
    assign pc_inc1 = cur_q.pc + XLEN'(1);
    assign pc_inc2 = cur_q.pc + XLEN'(2);

    wpc_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .ra_a  (ins.fa[RIDX_W-1:0]),
        .ra_b  (ins.fb[RIDX_W-1:0]),
        .ra_c  (ins.fc[RIDX_W-1:0]),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .rd_c  (rd_c),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    wpc_alu #(.XLEN(XLEN)) alu_i (
        .op  (ins.op),
        .x   (rd_b),
        .y   (rd_c),
        .res (alu_res)
    );

    wpc_branch_cmp #(.XLEN(XLEN)) cmp_i (
        .op   (ins.op),
        .lhs  (rd_a),
        .rhs  (rd_b),
        .take (take)
    );

    always_comb begin
        nxt_d      = cur_q;
        imem_addr  = cur_q.pc[IADDR_W-1:0];
        dmem_addr  = rd_b[DADDR_W-1:0];
        dmem_wdata = rd_b;
        dmem_we    = 1'b0;
        rf_we      = 1'b0;
        rf_waddr   = ins.fa[RIDX_W-1:0];
        rf_wdata   = alu_res;
        case (cur_q.st)
            ST_FETCH: begin
                nxt_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                nxt_d.ir  = imem_rdata;
                imem_addr = pc_inc1[IADDR_W-1:0];
                nxt_d.st  = is_two_word(imem_rdata[31:24]) ? ST_OPND : ST_EXEC;
            end
            ST_OPND: begin
                nxt_d.imm = imem_rdata;
                nxt_d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                nxt_d.st = ST_FETCH;
                nxt_d.pc = pc_inc1;
                if (ins.op == OP_JMP || is_cond_branch(ins.op)) begin
                    nxt_d.pc = take ? cur_q.imm : pc_inc2;
                end else if (ins.op == OP_MOVI) begin
                    rf_we    = 1'b1;
                    rf_wdata = cur_q.imm;
                    nxt_d.pc = pc_inc2;
                end else if (ins.op == OP_LOAD) begin
                    nxt_d.pc = cur_q.pc;
                    nxt_d.st = ST_LOAD;
                end else if (ins.op == OP_STORE) begin
                    dmem_we   = 1'b1;
                    dmem_addr = rd_a[DADDR_W-1:0];
                end else if (is_alu_op(ins.op)) begin
                    rf_we = 1'b1;
                end
            end
            ST_LOAD: begin
                rf_we    = 1'b1;
                rf_wdata = dmem_rdata;
                nxt_d.pc = pc_inc1;
                nxt_d.st = ST_FETCH;
            end
            default: begin
                nxt_d.st = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st  <= ST_FETCH;
            cur_q.pc  <= '0;
            cur_q.ir  <= '0;
            cur_q.imm <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R1
    reset_fetch_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (imem_addr == '0 && !dmem_we));

    // R8
    store_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R3
    movi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_EXEC && ins.op == OP_MOVI) |=> (cur_q.pc == $past(cur_q.pc) + XLEN'(2)));

    // R4
    alu_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_EXEC && is_alu_op(ins.op)) |=> (cur_q.pc == $past(cur_q.pc) + XLEN'(1)));

    // R7
    branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_EXEC && is_cond_branch(ins.op) && !take) |=> (cur_q.pc == $past(cur_q.pc) + XLEN'(2)));

    // R11
    exec_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_EXEC) |-> ($past(cur_q.st) == ST_DECODE || $past(cur_q.st) == ST_OPND));

endmodule

// File: tb/wordpair_cpu_tb.sv
`timescale 1ns/1ps
module wordpair_cpu_tb_top;

    localparam int          RUN_LIMIT = 60000;
    localparam logic [11:0] HALT      = 12'hFFF;
    localparam int          XS_COUNT  = 1500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_clear = 1'b0;
    logic [15:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [15:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [0:1023];
    logic [31:0] dmem [0:4095];
    logic [31:0] mm   [0:4095];
    logic [31:0] mr   [0:31];

    int n_chk = 0;
    int n_err = 0;
    int pcw   = 0;

    always #2 clk = ~clk;

    wordpair_cpu dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [31:0] fill(int i);
        return 32'hA5A5_0000 | 32'(i);
    endfunction

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[9:0]];
        if (mem_clear) begin
            for (int i = 0; i < 4096; i++) dmem[i] <= fill(i);
        end else begin
            if (dmem_we) dmem[dmem_addr[11:0]] <= dmem_wdata;
            dmem_rdata <= dmem[dmem_addr[11:0]];
        end
    end

    function automatic logic [31:0] enc(int op, int a, int b, int c);
        return {op[7:0], a[7:0], b[7:0], c[7:0]};
    endfunction

    function automatic logic [31:0] xs_step(logic [31:0] v);
        logic [31:0] t;
        t = v;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic bit cond_hold(int op, logic [31:0] x, logic [31:0] y);
        case (op)
            2: return x == y;
            3: return x != y;
            4: return x > y;
            5: return x >= y;
            6: return x < y;
            default: return x <= y;
        endcase
    endfunction

    task automatic put(logic [31:0] w);
        imem[pcw] = w;
        pcw++;
    endtask

    task automatic new_prog();
        for (int i = 0; i < 1024; i++) imem[i] = 32'h0;
        pcw = 0;
    endtask

    task automatic emit_halt();
        int here;
        put(enc(8, 30, 0, 0));
        put(32'(HALT));
        put(enc(11, 30, 0, 0));
        here = pcw;
        put(enc(1, 0, 0, 0));
        put(32'(here));
    endtask

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reset, run until the halt store, return execution cycles
    task automatic run_dut(bit chk_reset, output int cyc);
        rst = 1'b1;
        mem_clear = 1'b1;
        repeat (3) @(negedge clk);
        mem_clear = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        if (chk_reset) begin
            check32("R1 first fetch address", 32'(imem_addr), 32'h0);
            check32("R1 no write at reset", 32'(dmem_we), 32'h0);
        end
        while (!(dmem_we && dmem_addr[11:0] == HALT) && cyc < RUN_LIMIT) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (cyc >= RUN_LIMIT) begin
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog: actual=%0d expected<%0d cycles", cyc, RUN_LIMIT);
        end
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
    endtask

    // bench interpreter of the instruction set, stops at the halt store
    task automatic model_run();
        logic [31:0] pc, w, nx, va, vb, vc;
        int op, ia, ib, ic;
        bit done;
        done = 1'b0;
        for (int i = 0; i < 4096; i++) mm[i] = fill(i);
        for (int i = 0; i < 32; i++) mr[i] = 32'h0;
        pc = 32'h0;
        for (int s = 0; s < 300000 && !done; s++) begin
            w  = imem[pc[9:0]];
            nx = imem[pc[9:0] + 10'd1];
            op = int'(w[31:24]);
            ia = int'(w[20:16]);
            ib = int'(w[12:8]);
            ic = int'(w[4:0]);
            va = mr[ia];
            vb = mr[ib];
            vc = mr[ic];
            case (op)
                1: pc = nx;
                2, 3, 4, 5, 6, 7: pc = cond_hold(op, va, vb) ? nx : pc + 2;
                8: begin mr[ia] = nx; pc = pc + 2; end
                10: begin mr[ia] = mm[vb[11:0]]; pc = pc + 1; end
                11: begin
                    mm[va[11:0]] = vb;
                    pc = pc + 1;
                    if (va[11:0] == HALT) done = 1'b1;
                end
                12: begin mr[ia] = (vc >= 32) ? 32'h0 : vb << vc[4:0]; pc = pc + 1; end
                13: begin mr[ia] = (vc >= 32) ? 32'h0 : vb >> vc[4:0]; pc = pc + 1; end
                14: begin mr[ia] = ~vb; pc = pc + 1; end
                15: begin mr[ia] = vb & vc; pc = pc + 1; end
                16: begin mr[ia] = vb | vc; pc = pc + 1; end
                17: begin mr[ia] = vb ^ vc; pc = pc + 1; end
                18: begin mr[ia] = vb + vc; pc = pc + 1; end
                default: pc = pc + 1;
            endcase
        end
    endtask

    function automatic int rfield(int r);
        return ((int'($urandom % 8)) << 5) | r;
    endfunction

    task automatic gen_random(int n);
        int ops[6] = '{12, 13, 15, 16, 17, 18};
        int fillers[4] = '{0, 9, 19, 255};
        new_prog();
        for (int r = 0; r < 8; r++) begin
            put(enc(8, rfield(r), 0, 0));
            put(($urandom % 3 == 0) ? ($urandom % 40) : $urandom);
        end
        for (int k = 0; k < n; k++) begin
            int kind;
            kind = int'($urandom % 10);
            if (kind < 6) put(enc(ops[kind], rfield($urandom % 8), rfield($urandom % 8), rfield($urandom % 8)));
            else if (kind == 6) put(enc(14, rfield($urandom % 8), rfield($urandom % 8), 0));
            else if (kind == 7) put(enc(10, rfield($urandom % 8), rfield($urandom % 8), 0));
            else if (kind == 8) put(enc(11, rfield($urandom % 8), rfield($urandom % 8), 0));
            else put(enc(fillers[$urandom % 4], rfield($urandom % 8), rfield($urandom % 8), 0));
        end
        for (int r = 0; r < 8; r++) begin
            put(enc(8, 31, 0, 0));
            put(32'(100 + r));
            put(enc(11, 31, r, 0));
        end
        emit_halt();
    endtask

    initial begin
        int cyc;
        int bad;
        logic [31:0] xv;
        logic [31:0] pairs_x[4] = '{32'd7, 32'd3, 32'd9, 32'h8000_0000};
        logic [31:0] pairs_y[4] = '{32'd7, 32'd9, 32'd3, 32'd1};
        void'($urandom(32'h5EED_1234));

        // timing program: R11, R3
        new_prog();
        put(enc(8, 0, 0, 0)); put(32'd5);
        put(enc(8, 30, 0, 0)); put(32'(HALT));
        put(enc(0, 0, 0, 0));
        put(enc(11, 30, 0, 0));
        put(enc(1, 0, 0, 0)); put(32'd7);
        run_dut(1'b1, cyc);
        check32("R11 cycles to halt store", 32'(cyc), 32'd13);
        check32("R3 immediate stored", dmem[HALT], 32'd5);

        // directed program
        new_prog();
        put(enc(11, 0, 1, 0));
        put(enc(8, 0, 0, 0)); put(32'h0000_1234);
        put(enc(9, 0, 3, 3));
        put(enc(255, 8'hE0, 0, 0));
        put(enc(0, 0, 0, 0));
        put(enc(19, 0, 0, 0));
        put(enc(14, 1, 0, 0));
        put(enc(8, 7, 0, 0)); put(32'd50);
        put(enc(11, 7, 0, 0));
        put(enc(8, 7, 0, 0)); put(32'd51);
        put(enc(11, 7, 1, 0));
        put(enc(10, 2, 7, 0));
        put(enc(8, 7, 0, 0)); put(32'd52);
        put(enc(11, 7, 2, 0));
        put(enc(8, 3, 0, 0)); put(32'd60);
        put(enc(11, 3, 3, 0));
        put(enc(8, 4, 0, 0)); put(32'd7);
        put(enc(18, 8'h25, 8'hC4, 8'h64));
        put(enc(8, 7, 0, 0)); put(32'd53);
        put(enc(11, 7, 5, 0));
        emit_halt();
        run_dut(1'b0, cyc);
        check32("R1 register cleared by reset", dmem[0], 32'h0);
        check32("R10 undefined and NOP opcodes", dmem[50], 32'h0000_1234);
        check32("R5 NOT result", dmem[51], ~32'h0000_1234);
        check32("R9 load result", dmem[52], ~32'h0000_1234);
        check32("R8 store with a==b", dmem[60], 32'd60);
        check32("R8 neighbour untouched", dmem[61], fill(61));
        check32("R2 upper field bits ignored", dmem[53], 32'd14);

        // branch program: R7, R6
        new_prog();
        for (int op = 2; op <= 7; op++) begin
            for (int p = 0; p < 4; p++) begin
                int s;
                s = pcw;
                put(enc(8, 0, 0, 0)); put(pairs_x[p]);
                put(enc(8, 1, 0, 0)); put(pairs_y[p]);
                put(enc(op, 0, 1, 0)); put(32'(s + 10));
                put(enc(8, 2, 0, 0)); put(32'd1);
                put(enc(1, 0, 0, 0)); put(32'(s + 12));
                put(enc(8, 2, 0, 0)); put(32'd2);
                put(enc(8, 3, 0, 0)); put(32'(200 + (op - 2) * 4 + p));
                put(enc(11, 3, 2, 0));
            end
        end
        emit_halt();
        run_dut(1'b0, cyc);
        for (int op = 2; op <= 7; op++) begin
            for (int p = 0; p < 4; p++) begin
                check32($sformatf("R7 R6 branch op %0d pair %0d", op, p),
                        dmem[200 + (op - 2) * 4 + p],
                        cond_hold(op, pairs_x[p], pairs_y[p]) ? 32'd2 : 32'd1);
            end
        end

        // random programs: R4, R8, R9, R10, R2 against the interpreter
        for (int round = 0; round < 5; round++) begin
            gen_random(60);
            model_run();
            run_dut(1'b0, cyc);
            for (int r = 0; r < 8; r++) begin
                check32($sformatf("R4 random round %0d reg %0d", round, r), dmem[100 + r], mm[100 + r]);
            end
            bad = -1;
            for (int i = 0; i < 4095; i++) begin
                if (bad < 0 && dmem[i] !== mm[i]) bad = i;
            end
            check32($sformatf("R8 memory image round %0d", round),
                    (bad < 0) ? 32'h0 : dmem[bad], (bad < 0) ? 32'h0 : mm[bad]);
        end

        // xorshift loop: R12
        new_prog();
        put(enc(8, 0, 0, 0)); put(32'd1);
        put(enc(8, 1, 0, 0)); put(32'd0);
        put(enc(8, 2, 0, 0)); put(32'd1);
        put(enc(8, 3, 0, 0)); put(32'd13);
        put(enc(8, 4, 0, 0)); put(32'd17);
        put(enc(8, 5, 0, 0)); put(32'd5);
        put(enc(8, 8, 0, 0)); put(32'(XS_COUNT));
        put(enc(8, 9, 0, 0)); put(32'(HALT));
        put(enc(12, 6, 0, 3));
        put(enc(17, 0, 0, 6));
        put(enc(13, 6, 0, 4));
        put(enc(17, 0, 0, 6));
        put(enc(12, 6, 0, 5));
        put(enc(17, 0, 0, 6));
        put(enc(18, 1, 1, 2));
        put(enc(11, 1, 0, 0));
        put(enc(6, 1, 8, 0)); put(32'd16);
        put(enc(11, 9, 0, 0));
        put(enc(1, 0, 0, 0)); put(32'd27);
        run_dut(1'b0, cyc);
        xv = 32'd1;
        for (int k = 1; k <= XS_COUNT; k++) begin
            xv = xs_step(xv);
            check32($sformatf("R12 xorshift value %0d", k), dmem[k], xv);
        end
        check32("R12 no store past count", dmem[XS_COUNT + 1], fill(XS_COUNT + 1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule